// File: doc/BRIEF.md
# Watchdog Timer with Selectable Interrupt or Warm-Reset Expiry

A memory-mapped watchdog peripheral. A 32-bit counter advances by one on every system clock while the watchdog is enabled. When the counter matches a programmable compare value, the block records the expiry in two sticky flags and requests either a non-maskable interrupt or a warm reset, as selected by two enable bits. The timeout in ticks is the wanted interval in seconds multiplied by the clock frequency. An all-ones compare value gives the longest interval.

Software keeps the system alive by writing to the count register, normally with zero, before the compare value is reached. There are four registers on a simple register bus: control at 0x0, compare at 0x4, count at 0x8 and error-control at 0xC. All four are readable, and reads are combinational from the address. The two sticky timeout flags live in different registers and are cleared separately, each by writing its bit as 0.

Top module: `watchdog_timer`

## Requirements
- R1: After reset the control register reads 0, compare reads all-ones, count reads 0 and the error-control register reads 0, and neither request is asserted.
- R2: While the control enable bit (bit 0 at offset 0x0) is 1, the count increments by one per clock. While it is 0, the count does not change except by a bus write.
- R3: A write to the count register (offset 0x8) loads the written value. If the write lands in the same cycle as an expiry, the write wins and no expiry is recorded.
- R4: Expiry happens on the clock edge at which the enabled count equals compare. On that edge the control timeout flag (bit 1 at 0x0) and the error-control timeout flag (bit 2 at 0xC) both set, and the count then holds at the compare value.
- R5: If the NMI enable (bit 0 at 0xC) is 1 at expiry, nmi_req is a one-cycle pulse beginning on the expiry edge. It takes priority over the warm-reset enable, and the two requests are never high together.
- R6: If the NMI enable is 0 and the warm-reset enable (bit 1 at 0xC) is 1, warm_rst_req is a one-cycle pulse beginning on the expiry edge.
- R7: If both enables are 0, expiry only sets the flags and neither request pulses.
- R8: Each expiry issues at most one request. A held count does not fire again until a count write, a compare write or a disable re-arms the block.
- R9: Writing a timeout flag bit as 0 clears that flag only. Writing it as 1 leaves it unchanged, so the flag cannot be set from the bus.
- R10: The compare register (offset 0x4) reads back the written value, and the unused upper bits of the control and error-control registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which also serves as the watchdog tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (4) | Byte address of the register |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | CNT_W (32) | Write data |
| reg_rdata | output | CNT_W (32) | Read data for reg_addr |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| warm_rst_req | output | 1 | One-cycle warm-reset request |

## Verification
The bench goes after three groups of corner cases.

The first is the exact expiry cycle. A design that compares one tick late, or that keeps counting past the compare value, delivers its pulse in the wrong cycle, and the scoreboard keyed on cycle number rejects it.

The second is a count write that lands on the very edge of expiry. A design that lets the expiry win sets the flag and pulses where none may occur.

The third covers re-firing and flag handling. It holds at the compare value after a flag clear, re-arms through a compare write, uses both enables set, and uses neither set. A block that re-fires on a held count, lets a written 1 set a flag, or clears both flags together produces an unexpected pulse or a wrong readback.

// File: rtl/watchdog_timer.sv
module watchdog_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              nmi_req,
  output logic              warm_rst_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(12);
  localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic run_q, ctrl_to_q, nmi_en_q, rst_en_q, err_to_q, fired_q;

  wire wr_ctrl = reg_we && (reg_addr == A_CTRL);
  wire wr_cmp  = reg_we && (reg_addr == A_CMP);
  wire wr_cnt  = reg_we && (reg_addr == A_CNT);
  wire wr_err  = reg_we && (reg_addr == A_ERR);
  wire at_cmp  = (cnt_q == cmp_q);
  wire hit     = run_q && at_cmp && !wr_cnt && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= reg_wdata;
    end else if (run_q && !at_cmp) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '1;
    else if (wr_cmp) cmp_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      ctrl_to_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= reg_wdata[0];
      if (hit) ctrl_to_q <= 1'b1;
      else if (wr_ctrl) ctrl_to_q <= ctrl_to_q & reg_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_en_q <= 1'b0;
      rst_en_q <= 1'b0;
      err_to_q <= 1'b0;
    end else begin
      if (wr_err) begin
        nmi_en_q <= reg_wdata[0];
        rst_en_q <= reg_wdata[1];
      end
      if (hit) err_to_q <= 1'b1;
      else if (wr_err) err_to_q <= err_to_q & reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else if (wr_cnt || wr_cmp || !run_q) fired_q <= 1'b0;
    else if (hit) fired_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_req      <= 1'b0;
      warm_rst_req <= 1'b0;
    end else begin
      nmi_req      <= hit && nmi_en_q;
      warm_rst_req <= hit && !nmi_en_q && rst_en_q;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(CNT_W-2){1'b0}}, ctrl_to_q, run_q};
      A_CMP:   reg_rdata = cmp_q;
      A_CNT:   reg_rdata = cnt_q;
      A_ERR:   reg_rdata = {{(CNT_W-3){1'b0}}, err_to_q, rst_en_q, nmi_en_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/watchdog_timer_chk.sv
module watchdog_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [CNT_W-1:0]  reg_wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp,
  input logic              run,
  input logic              fired,
  input logic              ctrl_to,
  input logic              err_to,
  input logic              nmi_req,
  input logic              warm_rst_req
);
  wire cnt_wr = reg_we && (reg_addr == ADDR_W'(8));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && cnt != cmp) |=> cnt == $past(cnt) + CNT_W'(1));
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(reg_wdata));
  assert_hold_at_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && cnt == cmp) |=> $stable(cnt));
  assert_flags_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && cnt == cmp && !fired) |=> (ctrl_to && err_to));
  assert_nmi_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);
  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && warm_rst_req));
  assert_reset_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst_req |=> !warm_rst_req);
endmodule

bind watchdog_timer watchdog_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .cnt(cnt_q), .cmp(cmp_q), .run(run_q),
  .fired(fired_q), .ctrl_to(ctrl_to_q), .err_to(err_to_q),
  .nmi_req(nmi_req), .warm_rst_req(warm_rst_req)
);

// File: tb/watchdog_timer_bench.sv
module watchdog_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_req, warm_rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct { int kind; int at; } exp_t;
  exp_t sb[$];

  watchdog_timer u_watchdog_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_req(nmi_req), .warm_rst_req(warm_rst_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 20000 && !done) begin
    done = 1;
    errors++;
    $display("FAIL watchdog R4: run did not complete, actual cycle %0d expected < 20000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) if (rst_n && (nmi_req || warm_rst_req)) begin
    int kind;
    kind = nmi_req ? 1 : 2;
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL R8: unexpected request kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      exp_t e;
      e = sb.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        errors++;
        $display("FAIL R5/R6: request kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 kind, cyc, e.kind, e.at);
      end
    end
  end

  task automatic expect_req(input int kind, input int at);
    exp_t e;
    e.kind = kind;
    e.at = at;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: addr %0h actual %0h expected %0h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk_rd(4'h0, 32'h0, "R1 ctrl");
    chk_rd(4'h4, 32'hFFFF_FFFF, "R1 cmp");
    chk_rd(4'h8, 32'h0, "R1 cnt");
    chk_rd(4'hC, 32'h0, "R1 err");

    // R6 warm reset expiry, R2 counting, R4 hold and flags
    wr(4'h4, 32'd20);
    wr(4'hC, 32'h2);
    wr(4'h0, 32'h1);
    wr(4'h8, 32'h0);
    w = cyc;
    expect_req(2, w + 21);
    chk_rd(4'h8, 32'd1, "R2 count step");
    idle(30);
    chk_rd(4'h0, 32'h3, "R4 ctrl flag");
    chk_rd(4'hC, 32'h6, "R4 err flag");
    chk_rd(4'h8, 32'd20, "R4 hold at compare");

    // R9 independent clear, write-1 keeps, R8 no re-fire while held
    wr(4'h0, 32'h1);
    chk_rd(4'h0, 32'h1, "R9 ctrl cleared");
    chk_rd(4'hC, 32'h6, "R9 err untouched");
    wr(4'h0, 32'h3);
    chk_rd(4'h0, 32'h1, "R9 write one keeps zero");
    wr(4'hC, 32'h2);
    chk_rd(4'hC, 32'h2, "R9 err cleared");
    idle(5);
    chk_rd(4'h0, 32'h1, "R8 no refire");

    // R5 NMI priority with both enables set
    wr(4'hC, 32'h3);
    wr(4'h8, 32'h0);
    w = cyc;
    expect_req(1, w + 21);
    idle(30);
    chk_rd(4'hC, 32'h7, "R5 err flag");

    // R3 keep-alive by count writes
    wr(4'h0, 32'h1);
    wr(4'hC, 32'h3);
    for (int i = 0; i < 5; i++) begin
      wr(4'h8, 32'h0);
      idle(8);
    end
    chk_rd(4'h0, 32'h1, "R3 keep-alive no expiry");

    // R2 disabled holds, R3 load arbitrary value
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd7);
    idle(25);
    chk_rd(4'h8, 32'd7, "R2 disabled hold / R3 load");
    chk_rd(4'h0, 32'h0, "R2 disabled no flag");

    // R7 neither enable
    wr(4'hC, 32'h0);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'h1);
    idle(30);
    chk_rd(4'h0, 32'h3, "R7 ctrl flag only");
    chk_rd(4'hC, 32'h4, "R7 err flag only");

    // R3 count write on the expiry edge wins
    wr(4'h0, 32'h1);
    wr(4'hC, 32'h1);
    wr(4'h8, 32'h0);
    w = cyc;
    idle(19);
    wr(4'h8, 32'd5);
    checks++;
    if (cyc != w + 21) begin
      errors++;
      $display("FAIL R3: collision write cycle actual %0d expected %0d", cyc, w + 21);
    end
    expect_req(1, cyc + 16);
    chk_rd(4'h0, 32'h1, "R3 write beats expiry");
    idle(25);
    chk_rd(4'h0, 32'h3, "R3 later expiry");

    // R8 re-arm by compare write, R10 compare readback
    wr(4'h4, 32'd30);
    expect_req(1, cyc + 11);
    idle(20);
    chk_rd(4'h4, 32'd30, "R10 compare readback");
    chk_rd(4'h8, 32'd30, "R8 rearmed hold");

    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R5/R6: missing requests actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule